// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits beside a double-data-rate SDRAM interface and samples the command pins on every rising clock edge. It turns the chip-select, row-strobe, column-strobe and write-enable levels into a command code. It follows which of the banks are open, which row each one holds, and whether an access with automatic close is still counting down. It keeps its own copy of the base and extended mode registers.

Each command is checked against that state. An illegal command raises a one-cycle error pulse with a code that gives the reason, and the tracked state stays as it was. Closing after an access uses a countdown whose length comes from the burst length in the stored base mode register. The block also registers the data mask input as a per-byte write enable, so that later logic can gate write data with it.

All outputs are registered. They change one clock after the edge at which the command was sampled.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The command is decoded from {cs_ni, ras_ni, cas_ni, we_ni} and appears on cmd_o one clock later. cs_ni high gives NOP (code 0). Otherwise ras/cas/we give: 111 NOP=0, 011 activate=1, 101 read=2, 100 write=3, 110 burst terminate=4, 010 precharge=5, 001 with cke_i high auto refresh=6, 001 with cke_i low self refresh=7, 000 mode register set=8.
- R2: An activate to a closed bank opens it and stores addr_i as its row. An activate to an open bank raises err_o with err_code_o=2 and leaves the stored row unchanged.
- R3: A read or write to a bank that is closed, or whose automatic close is still pending, raises err_o with err_code_o=1 and changes no bank state.
- R4: A precharge with addr_i[10] low closes only bank ba_i. With addr_i[10] high it closes every bank and ba_i is ignored.
- R5: A mode register set with ba_i=0 loads addr_i into mode_base_o, and with ba_i=1 into mode_ext_o. ba_i of 2 or 3 raises err_code_o=5 and loads neither.
- R6: Auto refresh, self refresh and mode register set raise err_code_o=4 while any bank is open, and in that case change no mode register.
- R7: A read or write with addr_i[10] high closes its bank N clocks after the edge that sampled it. N is 1, 2 or 4 for mode_base_o[2:0] = 001, 010, 011, and 1 for any other value.
- R8: A burst terminate is legal only within N clocks after a read with addr_i[10] low, and only when no write has come since. In every other case it raises err_code_o=3.
- R9: wr_byte_en_o equals the inverse of dm_i, registered one clock. A low mask bit enables that byte.
- R10: While rst_ni is low, all banks read closed, both mode registers read zero, err_o is low, err_code_o is 0 and cmd_o is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples commands |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable pin level |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BA_W (2) | Bank address |
| addr_i | input | ADDR_W (12) | Row, column or op-code address |
| dm_i | input | DM_W (2) | Data mask, one bit per byte |
| cmd_o | output | 4 | Decoded command code |
| err_o | output | 1 | Protocol error pulse |
| err_code_o | output | 3 | Reason for the error |
| bank_open_o | output | NUM_BANKS (4) | Open flag per bank |
| open_row_o | output | NUM_BANKS*ADDR_W (48) | Stored row per bank, bank 0 in the low bits |
| mode_base_o | output | ADDR_W (12) | Base mode register copy |
| mode_ext_o | output | ADDR_W (12) | Extended mode register copy |
| wr_byte_en_o | output | DM_W (2) | Registered per-byte write enable |

## Verification
The bench builds the block with its default parameters: four banks, a 12-bit address with the close request on bit 10, and a 2-bit data mask. These values cover both reserved bank codes of a mode register set, precharge of a single bank and of all banks, and the full row width. The bench rewrites the base mode register between runs, so the automatic close countdown runs at all three lengths (1, 2 and 4 clocks), and it places a burst terminate at the last legal cycle of a read burst.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_WR   = 4'd3,
    CMD_BST  = 4'd4,
    CMD_PRE  = 4'd5,
    CMD_AREF = 4'd6,
    CMD_SREF = 4'd7,
    CMD_MRS  = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_NOT_OPEN   = 3'd1,
    ERR_ACT_OPEN   = 3'd2,
    ERR_BST        = 3'd3,
    ERR_BANKS_OPEN = 3'd4,
    ERR_MRS_RSVD   = 3'd5
  } err_e;

  // clocks per burst (double data rate: two beats per clock)
  function automatic logic [2:0] burst_clocks(input logic [2:0] bl_code);
    case (bl_code)
      3'd2:    return 3'd2;
      3'd3:    return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);

  always_comb begin
    cmd_o = CMD_NOP;
    if (!cs_ni) begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b110:  cmd_o = CMD_BST;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = cke_i ? CMD_AREF : CMD_SREF;
        3'b000:  cmd_o = CMD_MRS;
        default: cmd_o = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int ROW_W = 12,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic             ap_start_i,
  input  logic [CNT_W-1:0] ap_len_i,
  input  logic             close_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ap_pend_o
);

  logic [CNT_W-1:0] ap_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o   <= 1'b0;
      row_o    <= '0;
      ap_cnt_q <= '0;
    end else if (close_i) begin
      open_o   <= 1'b0;
      ap_cnt_q <= '0;
    end else if (act_i) begin
      open_o <= 1'b1;
      row_o  <= row_i;
    end else if (ap_start_i) begin
      ap_cnt_q <= ap_len_i;
    end else if (ap_cnt_q != '0) begin
      ap_cnt_q <= ap_cnt_q - 1'b1;
      if (ap_cnt_q == CNT_W'(1)) open_o <= 1'b0;
    end
  end

  assign ap_pend_o = (ap_cnt_q != '0);

  p_act_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i && !close_i |=> open_o && row_o == $past(row_i));

  p_ap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ap_start_i && !close_i |=> open_o && ap_pend_o);

  p_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_i |=> !open_o && !ap_pend_o);

endmodule

// File: rtl/sdram_read_burst.sv
module sdram_read_burst #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_start_i,
  input  logic             rd_ap_i,
  input  logic             wr_start_i,
  input  logic             bst_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             bst_ok_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             ap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else if (wr_start_i || bst_i) begin
      cnt_q <= '0;
      ap_q  <= 1'b0;
    end else if (rd_start_i) begin
      cnt_q <= len_i;
      ap_q  <= rd_ap_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign bst_ok_o = (cnt_q != '0) && !ap_q;

  p_bst_after_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_i |=> !bst_ok_o);

  p_bst_after_ap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_i && rd_ap_i && !wr_start_i && !bst_i |=> !bst_ok_o);

  p_bst_plain_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_i && !rd_ap_i && !wr_start_i && !bst_i |=> bst_ok_o);

endmodule

// File: rtl/sdram_mode_regs.sv
module sdram_mode_regs #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         sel_ext_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] base_o,
  output logic [W-1:0] ext_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      ext_o  <= '0;
    end else if (load_i) begin
      if (sel_ext_i) ext_o  <= data_i;
      else           base_o <= data_i;
    end
  end

  p_load_base_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && !sel_ext_i |=> base_o == $past(data_i) && $stable(ext_o));

  p_load_ext_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && sel_ext_i |=> ext_o == $past(data_i) && $stable(base_o));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 12,
  parameter int DM_W      = 2,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int MAX_CLKS = 4,
  localparam int CNT_W    = $clog2(MAX_CLKS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cke_i,
  input  logic                        cs_ni,
  input  logic                        ras_ni,
  input  logic                        cas_ni,
  input  logic                        we_ni,
  input  logic [BA_W-1:0]             ba_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DM_W-1:0]             dm_i,
  output logic [3:0]                  cmd_o,
  output logic                        err_o,
  output logic [2:0]                  err_code_o,
  output logic [NUM_BANKS-1:0]        bank_open_o,
  output logic [NUM_BANKS*ADDR_W-1:0] open_row_o,
  output logic [ADDR_W-1:0]           mode_base_o,
  output logic [ADDR_W-1:0]           mode_ext_o,
  output logic [DM_W-1:0]             wr_byte_en_o
);

  cmd_e                 cmd;
  err_e                 err_n;
  logic                 ok;
  logic                 ap_req;
  logic                 any_open;
  logic                 sel_open;
  logic                 sel_pend;
  logic                 bst_ok;
  logic                 is_access;
  logic [CNT_W-1:0]     burst_len;
  logic [NUM_BANKS-1:0] bank_open;
  logic [NUM_BANKS-1:0] ap_pend;

  sdram_cmd_decode u_decode (
    .cke_i  (cke_i),
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cmd_o  (cmd)
  );

  assign ap_req    = addr_i[AP_BIT];
  assign any_open  = |bank_open;
  assign sel_open  = bank_open[ba_i];
  assign sel_pend  = ap_pend[ba_i];
  assign is_access = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign burst_len = CNT_W'(burst_clocks(mode_base_o[2:0]));

  // legality; first failing rule wins
  always_comb begin
    err_n = ERR_NONE;
    unique case (cmd)
      CMD_ACT:           if (sel_open) err_n = ERR_ACT_OPEN;
      CMD_RD, CMD_WR:    if (!sel_open || sel_pend) err_n = ERR_NOT_OPEN;
      CMD_BST:           if (!bst_ok) err_n = ERR_BST;
      CMD_AREF, CMD_SREF: if (any_open) err_n = ERR_BANKS_OPEN;
      CMD_MRS: begin
        if (any_open)                err_n = ERR_BANKS_OPEN;
        else if (ba_i > BA_W'(1))    err_n = ERR_MRS_RSVD;
      end
      default: err_n = ERR_NONE;
    endcase
  end

  assign ok = (err_n == ERR_NONE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    logic [ADDR_W-1:0] row_q;

    assign hit = (ba_i == BA_W'(b));

    sdram_bank_state #(
      .ROW_W (ADDR_W),
      .CNT_W (CNT_W)
    ) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .act_i      (ok && cmd == CMD_ACT && hit),
      .row_i      (addr_i),
      .ap_start_i (ok && is_access && ap_req && hit),
      .ap_len_i   (burst_len),
      .close_i    (cmd == CMD_PRE && (ap_req || hit)),
      .open_o     (bank_open[b]),
      .row_o      (row_q),
      .ap_pend_o  (ap_pend[b])
    );

    assign open_row_o[b*ADDR_W +: ADDR_W] = row_q;
  end

  sdram_read_burst #(
    .CNT_W (CNT_W)
  ) u_burst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_start_i (ok && cmd == CMD_RD),
    .rd_ap_i    (ap_req),
    .wr_start_i (ok && cmd == CMD_WR),
    .bst_i      (ok && cmd == CMD_BST),
    .len_i      (burst_len),
    .bst_ok_o   (bst_ok)
  );

  sdram_mode_regs #(
    .W (ADDR_W)
  ) u_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ok && cmd == CMD_MRS),
    .sel_ext_i (ba_i[0]),
    .data_i    (addr_i),
    .base_o    (mode_base_o),
    .ext_o     (mode_ext_o)
  );

  assign bank_open_o = bank_open;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o        <= CMD_NOP;
      err_o        <= 1'b0;
      err_code_o   <= ERR_NONE;
      wr_byte_en_o <= '0;
    end else begin
      cmd_o        <= cmd;
      err_o        <= !ok;
      err_code_o   <= err_n;
      wr_byte_en_o <= ~dm_i;
    end
  end

  p_pre_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_PRE && ap_req |=> bank_open_o == '0);

  p_access_closed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_access && !sel_open |=> err_o && err_code_o == ERR_NOT_OPEN
      && !bank_open_o[$past(ba_i)]);

  p_mrs_rsvd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_MRS && !any_open && ba_i > BA_W'(1)
      |=> err_o && err_code_o == ERR_MRS_RSVD && $stable(mode_base_o) && $stable(mode_ext_o));

  p_busy_refresh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_AREF || cmd == CMD_SREF || cmd == CMD_MRS) && any_open
      |=> err_o && err_code_o == ERR_BANKS_OPEN && $stable(mode_base_o));

  p_act_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd == CMD_ACT && sel_open |=> err_o && err_code_o == ERR_ACT_OPEN);

  p_err_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o == (err_code_o != ERR_NONE));

endmodule

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;

  localparam int CLK_P = 10;

  localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_BST = 4,
                 C_PRE = 5, C_AREF = 6, C_SREF = 7, C_MRS = 8;
  localparam int AP = 12'h400;

  typedef struct {
    string       req;
    int          cmd;
    int          code;
    logic [3:0]  open;
    logic [1:0]  wbe;
    logic [11:0] base;
    logic [11:0] ext;
    int          rb;
    logic [11:0] row;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [1:0]  dm = '0;
  logic [3:0]  cmd_o;
  logic        err_o;
  logic [2:0]  err_code_o;
  logic [3:0]  bank_open_o;
  logic [47:0] open_row_o;
  logic [11:0] mode_base_o, mode_ext_o;
  logic [1:0]  wr_byte_en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  item_t q[$];
  logic [3:0]  e_open = '0;
  logic [11:0] e_base = '0, e_ext = '0;
  int          e_rb = -1;
  logic [11:0] e_row = '0;

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_monitor u_sdram_cmd_monitor (
    .clk_i(clk), .rst_ni(rst_n), .cke_i(cke), .cs_ni(cs_n), .ras_ni(ras_n),
    .cas_ni(cas_n), .we_ni(we_n), .ba_i(ba), .addr_i(addr), .dm_i(dm),
    .cmd_o(cmd_o), .err_o(err_o), .err_code_o(err_code_o),
    .bank_open_o(bank_open_o), .open_row_o(open_row_o),
    .mode_base_o(mode_base_o), .mode_ext_o(mode_ext_o),
    .wr_byte_en_o(wr_byte_en_o)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R1 pin encoding {ras,cas,we} with cs low
  task automatic issue(string req, int c, int b, int a, logic [1:0] m, int code);
    @(negedge clk);
    cs_n = 1'b0;
    cke  = (c == C_SREF) ? 1'b0 : 1'b1;
    case (c)
      C_ACT:          {ras_n, cas_n, we_n} = 3'b011;
      C_RD:           {ras_n, cas_n, we_n} = 3'b101;
      C_WR:           {ras_n, cas_n, we_n} = 3'b100;
      C_BST:          {ras_n, cas_n, we_n} = 3'b110;
      C_PRE:          {ras_n, cas_n, we_n} = 3'b010;
      C_AREF, C_SREF: {ras_n, cas_n, we_n} = 3'b001;
      C_MRS:          {ras_n, cas_n, we_n} = 3'b000;
      default:        {ras_n, cas_n, we_n} = 3'b111;
    endcase
    ba = 2'(b); addr = 12'(a); dm = m;
    q.push_back('{req, c, code, e_open, ~m, e_base, e_ext, e_rb, e_row});
    e_rb = -1;
  endtask

  task automatic nop(string req);
    issue(req, C_NOP, 0, 0, 2'b00, 0);
  endtask

  // monitor: pops one expectation per edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (q.size() != 0) begin
        item_t it;
        it = q.pop_front();
        check(it.req, "cmd", int'(cmd_o), it.cmd);
        check(it.req, "err", int'(err_o), int'(it.code != 0));
        check(it.req, "code", int'(err_code_o), it.code);
        check(it.req, "open", int'(bank_open_o), int'(it.open));
        check("R9", "wbe", int'(wr_byte_en_o), int'(it.wbe));
        check(it.req, "base", int'(mode_base_o), int'(it.base));
        check(it.req, "ext", int'(mode_ext_o), int'(it.ext));
        if (it.rb >= 0)
          check(it.req, "row", int'(open_row_o[it.rb*12 +: 12]), int'(it.row));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    check("R10", "rst cmd", int'(cmd_o), C_NOP);
    check("R10", "rst err", int'(err_o), 0);
    check("R10", "rst code", int'(err_code_o), 0);
    check("R10", "rst open", int'(bank_open_o), 0);
    check("R10", "rst base", int'(mode_base_o), 0);
    check("R10", "rst ext", int'(mode_ext_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5 mode register routing
    e_base = 12'h032;
    issue("R5", C_MRS, 0, 12'h032, 2'b00, 0);
    e_ext = 12'h0A5;
    issue("R5", C_MRS, 1, 12'h0A5, 2'b01, 0);
    issue("R5", C_MRS, 2, 12'hFFF, 2'b10, 5);
    issue("R5", C_MRS, 3, 12'h111, 2'b11, 5);

    // R2 activate
    e_open = 4'b0001; e_rb = 0; e_row = 12'h123;
    issue("R2", C_ACT, 0, 12'h123, 2'b00, 0);
    e_rb = 0; e_row = 12'h123;
    issue("R2", C_ACT, 0, 12'h456, 2'b00, 2);

    // R3 access to closed banks
    issue("R3", C_RD, 1, 12'h010, 2'b00, 1);
    issue("R3", C_WR, 2, 12'h020, 2'b00, 1);
    e_open = 4'b0101; e_rb = 2; e_row = 12'hABC;
    issue("R2", C_ACT, 2, 12'hABC, 2'b00, 0);

    // R8 terminate rules (BL4 -> 2 clocks)
    issue("R8", C_RD, 0, 12'h008, 2'b00, 0);
    issue("R8", C_BST, 0, 0, 2'b00, 0);
    issue("R8", C_BST, 0, 0, 2'b00, 3);
    issue("R8", C_RD, 0, 12'h008, 2'b00, 0);
    nop("R8");
    issue("R8", C_BST, 0, 0, 2'b00, 0);
    issue("R8", C_RD, 0, 12'h008, 2'b00, 0);
    nop("R8");
    nop("R8");
    issue("R8", C_BST, 0, 0, 2'b00, 3);
    issue("R9", C_WR, 2, 12'h004, 2'b01, 0);
    issue("R8", C_BST, 0, 0, 2'b10, 3);

    // R6 refresh and mode set with banks open
    issue("R6", C_AREF, 0, 0, 2'b00, 4);
    issue("R6", C_SREF, 0, 0, 2'b00, 4);
    issue("R6", C_MRS, 0, 12'h7FF, 2'b00, 4);

    // R7 auto close, 2 clocks; terminate after it is illegal (R8)
    issue("R7", C_RD, 0, AP | 12'h00C, 2'b00, 0);
    issue("R8", C_BST, 0, 0, 2'b00, 3);
    e_open = 4'b0100;
    nop("R7");
    issue("R7", C_WR, 2, AP | 12'h001, 2'b00, 0);
    issue("R3", C_RD, 2, 12'h001, 2'b00, 1);
    e_open = 4'b0000;
    nop("R7");

    // R4 precharge
    e_open = 4'b0010; e_rb = 1; e_row = 12'h001;
    issue("R2", C_ACT, 1, 12'h001, 2'b00, 0);
    e_open = 4'b1010; e_rb = 3; e_row = 12'hFFF;
    issue("R2", C_ACT, 3, 12'hFFF, 2'b00, 0);
    e_open = 4'b1000;
    issue("R4", C_PRE, 1, 12'h000, 2'b00, 0);
    e_open = 4'b1001;
    issue("R2", C_ACT, 0, 12'h555, 2'b00, 0);
    e_open = 4'b0000;
    issue("R4", C_PRE, 1, AP, 2'b00, 0);

    // R6 legal refresh once closed, R1 cke selects kind
    issue("R6", C_SREF, 2, 12'hFFF, 2'b11, 0);
    issue("R6", C_AREF, 1, 0, 2'b00, 0);

    // R7 auto close, 1 clock
    e_base = 12'h031;
    issue("R7", C_MRS, 0, 12'h031, 2'b00, 0);
    e_open = 4'b0010;
    issue("R7", C_ACT, 1, 12'h0F0, 2'b00, 0);
    issue("R7", C_RD, 1, AP, 2'b00, 0);
    e_open = 4'b0000;
    nop("R7");

    // R7 auto close, 4 clocks
    e_base = 12'h033;
    issue("R7", C_MRS, 0, 12'h033, 2'b00, 0);
    e_open = 4'b1000;
    issue("R7", C_ACT, 3, 12'h0F0, 2'b00, 0);
    issue("R7", C_WR, 3, AP | 12'h002, 2'b00, 0);
    nop("R7");
    nop("R7");
    nop("R7");
    e_open = 4'b0000;
    nop("R7");

    // R1 deselect overrides other pins
    @(negedge clk);
    cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b000; ba = 2'd0; addr = 12'hFFF; dm = 2'b00;
    q.push_back('{"R1", C_NOP, 0, e_open, 2'b11, e_base, e_ext, -1, 12'h000});
    nop("R1");

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule